// File: doc/BRIEF.md
# Compact Byte/Halfword and Unary Instruction Expander

This block turns one 16-bit compressed RISC-V instruction into the 32-bit base instruction that does the same work. It also raises a flag when the halfword cannot be expanded. It covers two groups of compressed encodings and nothing else:

- **Quadrant 0, funct3 `100`:** short byte and halfword memory accesses. These take an unsigned offset of two bits. Both registers come from the compact register set x8..x15.
- **Quadrant 1, funct3 `100`, bits 12:10 = `111`:** register-to-register operations. These are the word add and subtract, a multiply, and six unary operations (zero or sign extension, and bitwise inversion).

A width input tells the block whether the core runs 32-bit or 64-bit. This input decides which encodings are legal, and for one operation it also decides which opcode is produced.

A decode stage places the block between fetch and the main decoder. By default the result is registered, so the expansion appears one clock after the halfword is presented. A parameter can remove that register and leave the path purely combinational.

Any encoding outside the two groups, and any reserved code inside them, gives all-zero output with the flag set.

Top module: `cinsn_expand`

## Requirements
- R1: When `insn_i[1:0]` is `10` or `11`, `insn_i[15:13]` is not `100`, or quadrant 1 has `insn_i[12:10]` other than `111`, then `bad_o` is 1 and `insn_o` is all zeros. Every illegal result drives `insn_o` to zero.
- R2: Quadrant 0 selector `insn_i[12:10]=000` expands to `lbu` with rd = {01,`insn_i[4:2]`}, rs1 = {01,`insn_i[9:7]`}, funct3 100 and opcode 0000011. The offset takes `insn_i[5]` as bit 1 and `insn_i[6]` as bit 0, zero-extended to 12 bits.
- R3: Selector `001` is a halfword load. With `insn_i[6]=0` it becomes `lhu` (funct3 101). With `insn_i[6]=1` it becomes `lh` (funct3 001). The offset is {`insn_i[5]`,0}.
- R4: Selector `010` expands to `sb` with rs2 = {01,`insn_i[4:2]`}, rs1 = {01,`insn_i[9:7]`}, funct3 000 and opcode 0100011. The offset is the same swapped-bit offset as in R2, placed in the low immediate field.
- R5: Selector `011` with `insn_i[6]=0` expands to `sh` (funct3 001) with offset {`insn_i[5]`,0}. `011` with `insn_i[6]=1` is illegal, and so are selectors `1xx`.
- R6: In the quadrant 1 group, `insn_i[6:5]=00` expands to `subw` (funct7 0100000) and `01` expands to `addw` (funct7 0000000). Both use rd = rs1 = {01,`insn_i[9:7]`}, rs2 = {01,`insn_i[4:2]`} and opcode 0111011. Both are legal only when `wide_i=1`.
- R7: `insn_i[6:5]=10` expands to `mul rd,rd,rs2` (funct7 0000001, funct3 000, opcode 0110011) at either width.
- R8: `insn_i[6:5]=11` selects a unary operation by `insn_i[4:2]`. `000` becomes `andi rd,rd,255`. `001` becomes sign-extend-byte (imm 0x604, funct3 001, opcode 0010011). `011` becomes sign-extend-half (imm 0x605). `101` becomes `xori rd,rd,-1`.
- R9: Unary code `010` (zero-extend half) becomes funct7 0000100, rs2 x0, funct3 100. The opcode is 0110011 when `wide_i=0` and 0111011 when `wide_i=1`.
- R10: Unary code `100` becomes `add.uw rd,rd,x0` (funct7 0000100, funct3 000, opcode 0111011) when `wide_i=1`, and is illegal when `wide_i=0`.
- R11: Unary codes `110` and `111` are illegal.
- R12: With `REG_OUT=1`, outputs change one clock after the inputs. While `rst` is high at a rising edge, the next outputs are `insn_o=0` and `bad_o=0`.
- R13: Every legal expansion has its rs1 field (`insn_o[19:15]`) in x8..x15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 16 | Compressed instruction halfword |
| wide_i | input | 1 | 1 for a 64-bit core, 0 for a 32-bit core |
| insn_o | output | 32 | Expanded base instruction, zero when illegal |
| bad_o | output | 1 | Expansion illegal |

## Verification
The hardest cases come from the width input, not from the halfword. The same halfword must give a legal result at one width and an illegal one at the other: word add/subtract and the zero-extend-word code. The zero-extend-half code is harder still, because it stays legal at both widths but changes opcode. The bench therefore presents each of these halfwords twice in a row, flipping only `wide_i` between the two, so that nothing else can explain a change in the output. It also sweeps all four offset bit combinations, so the swapped bit order of the byte offset is visible at the output.

// File: rtl/cinsn_pkg.sv
package cinsn_pkg;
  localparam int CW = 16;
  localparam int XW = 32;

  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_REG   = 7'b0110011;
  localparam logic [6:0] OP_REG32 = 7'b0111011;

  typedef struct packed {
    logic          bad;
    logic [XW-1:0] word;
  } xres_t;

  function automatic logic [4:0] creg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [XW-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [XW-1:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [XW-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
  endfunction
endpackage

// File: rtl/cinsn_mem_dec.sv
module cinsn_mem_dec
  import cinsn_pkg::*;
(
  input  logic [CW-1:0] insn,
  output xres_t         res
);
  logic [4:0]  base_r;
  logic [4:0]  data_r;
  logic [11:0] off_b;
  logic [11:0] off_h;

  always_comb begin
    base_r = creg(insn[9:7]);
    data_r = creg(insn[4:2]);
    off_b  = {10'd0, insn[5], insn[6]};
    off_h  = {10'd0, insn[5], 1'b0};
    res    = '{bad: 1'b1, word: '0};
    if (insn[1:0] == 2'b00 && insn[15:13] == 3'b100) begin
      unique case (insn[12:10])
        3'b000: res = '{bad: 1'b0, word: enc_i(off_b, base_r, 3'b100, data_r, OP_LOAD)};
        3'b001: res = '{bad: 1'b0,
                        word: enc_i(off_h, base_r, insn[6] ? 3'b001 : 3'b101, data_r, OP_LOAD)};
        3'b010: res = '{bad: 1'b0, word: enc_s(off_b, data_r, base_r, 3'b000)};
        3'b011: if (!insn[6]) res = '{bad: 1'b0, word: enc_s(off_h, data_r, base_r, 3'b001)};
        default: res = '{bad: 1'b1, word: '0};
      endcase
    end
  end
endmodule

// File: rtl/cinsn_alu_dec.sv
module cinsn_alu_dec
  import cinsn_pkg::*;
(
  input  logic [CW-1:0] insn,
  input  logic          wide,
  output xres_t         res
);
  logic [4:0] dst_r;
  logic [4:0] src_r;

  always_comb begin
    dst_r = creg(insn[9:7]);
    src_r = creg(insn[4:2]);
    res   = '{bad: 1'b1, word: '0};
    if (insn[1:0] == 2'b01 && insn[15:10] == 6'b100111) begin
      unique case (insn[6:5])
        2'b00: if (wide) res = '{bad: 1'b0,
                                 word: enc_r(7'b0100000, src_r, dst_r, 3'b000, dst_r, OP_REG32)};
        2'b01: if (wide) res = '{bad: 1'b0,
                                 word: enc_r(7'b0000000, src_r, dst_r, 3'b000, dst_r, OP_REG32)};
        2'b10: res = '{bad: 1'b0, word: enc_r(7'b0000001, src_r, dst_r, 3'b000, dst_r, OP_REG)};
        default: begin
          unique case (insn[4:2])
            3'b000: res = '{bad: 1'b0, word: enc_i(12'h0FF, dst_r, 3'b111, dst_r, OP_IMM)};
            3'b001: res = '{bad: 1'b0, word: enc_i(12'h604, dst_r, 3'b001, dst_r, OP_IMM)};
            3'b010: res = '{bad: 1'b0,
                            word: enc_r(7'b0000100, 5'd0, dst_r, 3'b100, dst_r,
                                        wide ? OP_REG32 : OP_REG)};
            3'b011: res = '{bad: 1'b0, word: enc_i(12'h605, dst_r, 3'b001, dst_r, OP_IMM)};
            3'b100: if (wide) res = '{bad: 1'b0,
                                      word: enc_r(7'b0000100, 5'd0, dst_r, 3'b000, dst_r, OP_REG32)};
            3'b101: res = '{bad: 1'b0, word: enc_i(12'hFFF, dst_r, 3'b100, dst_r, OP_IMM)};
            default: res = '{bad: 1'b1, word: '0};
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/cinsn_expand.sv
module cinsn_expand
  import cinsn_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] insn_i,
  input  logic          wide_i,
  output logic [XW-1:0] insn_o,
  output logic          bad_o
);
  xres_t mem_res;
  xres_t alu_res;
  xres_t sel_res;

  cinsn_mem_dec u_mem (.insn(insn_i), .res(mem_res));
  cinsn_alu_dec u_alu (.insn(insn_i), .wide(wide_i), .res(alu_res));

  always_comb begin
    if (!mem_res.bad)      sel_res = mem_res;
    else if (!alu_res.bad) sel_res = alu_res;
    else                   sel_res = '{bad: 1'b1, word: '0};
  end

  generate
    if (REG_OUT) begin : g_reg
      xres_t q;
      always_ff @(posedge clk) begin
        if (rst) q <= '{bad: 1'b0, word: '0};
        else     q <= sel_res;
      end
      assign insn_o = q.word;
      assign bad_o  = q.bad;
    end else begin : g_comb
      assign insn_o = sel_res.word;
      assign bad_o  = sel_res.bad;
    end
  endgenerate
endmodule

// File: rtl/cinsn_expand_chk.sv
module cinsn_expand_chk
  import cinsn_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] insn_i,
  input logic          wide_i,
  input logic [XW-1:0] insn_o,
  input logic          bad_o
);
  // R1
  always_comb begin
    if (bad_o) bad_zero_chk: assert (insn_o == '0);
  end

  generate
    if (REG_OUT) begin : g_seq
      // R12
      reset_clear_chk: assert property (@(posedge clk) rst |=> (insn_o == '0 && !bad_o));
      // R1
      quad_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(insn_i[1])) |-> bad_o);
      // R6
      narrow_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!wide_i && insn_i[1:0] == 2'b01 && insn_i[15:10] == 6'b100111
                              && !insn_i[6])) |-> bad_o);
      // R10
      narrow_zw_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!wide_i && insn_i == {6'b100111, 3'b000, 2'b11, 3'b100, 2'b01}))
        |-> bad_o);
      // R13
      rs1_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !bad_o && insn_o != '0) |-> insn_o[19:18] == 2'b01);
    end
  endgenerate
endmodule

bind cinsn_expand cinsn_expand_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_cinsn_expand.sv
`timescale 1ns/1ps
module test_cinsn_expand;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] insn_i = '0;
  logic        wide_i = 1'b0;
  logic [31:0] insn_o;
  logic        bad_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cinsn_expand i_cinsn_expand (.clk(clk), .rst(rst), .insn_i(insn_i), .wide_i(wide_i),
                               .insn_o(insn_o), .bad_o(bad_o));

  function automatic logic [4:0] r8(input logic [2:0] f); return {2'b01, f}; endfunction
  function automatic logic [15:0] mk0(input logic [2:0] sel, input logic [2:0] b,
                                      input logic b6, input logic b5, input logic [2:0] d);
    return {3'b100, sel, b, b6, b5, d, 2'b00};
  endfunction
  function automatic logic [15:0] mk1(input logic [1:0] op, input logic [2:0] d,
                                      input logic [2:0] s);
    return {6'b100111, d, op, s, 2'b01};
  endfunction
  function automatic logic [31:0] ity(input logic [11:0] im, input logic [4:0] a,
                                      input logic [2:0] f, input logic [4:0] d, input logic [6:0] o);
    return {im, a, f, d, o};
  endfunction
  function automatic logic [31:0] rty(input logic [6:0] f7, input logic [4:0] b, input logic [4:0] a,
                                      input logic [2:0] f, input logic [4:0] d, input logic [6:0] o);
    return {f7, b, a, f, d, o};
  endfunction
  function automatic logic [31:0] sty(input logic [11:0] im, input logic [4:0] b,
                                      input logic [4:0] a, input logic [2:0] f);
    return {im[11:5], b, a, f, im[4:0], 7'b0100011};
  endfunction

  task automatic apply(input logic [15:0] c, input logic w);
    @(negedge clk);
    insn_i = c;
    wide_i = w;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic eb, input logic [31:0] ew);
    n_chk++;
    if (bad_o !== eb || insn_o !== ew) begin
      n_bad++;
      $display("FAIL %s: got bad=%0b insn=%h, expected bad=%0b insn=%h", tag, bad_o, insn_o, eb, ew);
    end
  endtask

  task automatic t_reset;
    expect_out("R12 reset", 1'b0, 32'h0);
  endtask

  task automatic t_outside;
    apply(16'h4082, 1'b1); expect_out("R1 quadrant2", 1'b1, 32'h0);
    apply(16'h0013, 1'b1); expect_out("R1 quadrant3", 1'b1, 32'h0);
    apply(16'h4000, 1'b1); expect_out("R1 q0 other funct3", 1'b1, 32'h0);
    apply({6'b100011, 3'd1, 2'b00, 3'd2, 2'b01}, 1'b1); expect_out("R1 q1 bit12 zero", 1'b1, 32'h0);
  endtask

  task automatic t_lbu;
    for (int k = 0; k < 4; k++) begin
      logic b6, b5;
      b6 = k[1]; b5 = k[0];
      apply(mk0(3'b000, 3'd3, b6, b5, 3'd6), 1'b0);
      expect_out("R2 lbu", 1'b0, ity({10'd0, b5, b6}, r8(3), 3'b100, r8(6), 7'b0000011));
    end
  endtask

  task automatic t_half_load;
    apply(mk0(3'b001, 3'd7, 1'b0, 1'b1, 3'd0), 1'b1);
    expect_out("R3 lhu", 1'b0, ity(12'd2, r8(7), 3'b101, r8(0), 7'b0000011));
    apply(mk0(3'b001, 3'd1, 1'b1, 1'b0, 3'd5), 1'b1);
    expect_out("R3 lh", 1'b0, ity(12'd0, r8(1), 3'b001, r8(5), 7'b0000011));
    apply(mk0(3'b001, 3'd1, 1'b1, 1'b1, 3'd5), 1'b0);
    expect_out("R3 lh off2", 1'b0, ity(12'd2, r8(1), 3'b001, r8(5), 7'b0000011));
  endtask

  task automatic t_stores;
    apply(mk0(3'b010, 3'd2, 1'b1, 1'b0, 3'd4), 1'b0);
    expect_out("R4 sb off1", 1'b0, sty(12'd1, r8(4), r8(2), 3'b000));
    apply(mk0(3'b010, 3'd2, 1'b0, 1'b1, 3'd4), 1'b0);
    expect_out("R4 sb off2", 1'b0, sty(12'd2, r8(4), r8(2), 3'b000));
    apply(mk0(3'b011, 3'd5, 1'b0, 1'b1, 3'd7), 1'b1);
    expect_out("R5 sh", 1'b0, sty(12'd2, r8(7), r8(5), 3'b001));
    apply(mk0(3'b011, 3'd5, 1'b1, 1'b1, 3'd7), 1'b1);
    expect_out("R5 sh bit6 set", 1'b1, 32'h0);
    apply(mk0(3'b101, 3'd5, 1'b0, 1'b0, 3'd7), 1'b1);
    expect_out("R5 selector 1xx", 1'b1, 32'h0);
  endtask

  task automatic t_word_ops;
    apply(mk1(2'b00, 3'd2, 3'd3), 1'b1);
    expect_out("R6 subw wide", 1'b0, rty(7'b0100000, r8(3), r8(2), 3'b000, r8(2), 7'b0111011));
    apply(mk1(2'b00, 3'd2, 3'd3), 1'b0);
    expect_out("R6 subw narrow", 1'b1, 32'h0);
    apply(mk1(2'b01, 3'd6, 3'd1), 1'b1);
    expect_out("R6 addw wide", 1'b0, rty(7'b0000000, r8(1), r8(6), 3'b000, r8(6), 7'b0111011));
    apply(mk1(2'b01, 3'd6, 3'd1), 1'b0);
    expect_out("R6 addw narrow", 1'b1, 32'h0);
  endtask

  task automatic t_mul;
    apply(mk1(2'b10, 3'd4, 3'd7), 1'b0);
    expect_out("R7 mul narrow", 1'b0, rty(7'b0000001, r8(7), r8(4), 3'b000, r8(4), 7'b0110011));
    apply(mk1(2'b10, 3'd0, 3'd5), 1'b1);
    expect_out("R7 mul wide", 1'b0, rty(7'b0000001, r8(5), r8(0), 3'b000, r8(0), 7'b0110011));
  endtask

  task automatic t_unary;
    apply(mk1(2'b11, 3'd3, 3'b000), 1'b0);
    expect_out("R8 zext.b", 1'b0, ity(12'h0FF, r8(3), 3'b111, r8(3), 7'b0010011));
    apply(mk1(2'b11, 3'd5, 3'b001), 1'b1);
    expect_out("R8 sext.b", 1'b0, ity(12'h604, r8(5), 3'b001, r8(5), 7'b0010011));
    apply(mk1(2'b11, 3'd1, 3'b011), 1'b0);
    expect_out("R8 sext.h", 1'b0, ity(12'h605, r8(1), 3'b001, r8(1), 7'b0010011));
    apply(mk1(2'b11, 3'd7, 3'b101), 1'b1);
    expect_out("R8 not", 1'b0, ity(12'hFFF, r8(7), 3'b100, r8(7), 7'b0010011));
    apply(mk1(2'b11, 3'd2, 3'b010), 1'b0);
    expect_out("R9 zext.h narrow", 1'b0, rty(7'b0000100, 5'd0, r8(2), 3'b100, r8(2), 7'b0110011));
    apply(mk1(2'b11, 3'd2, 3'b010), 1'b1);
    expect_out("R9 zext.h wide", 1'b0, rty(7'b0000100, 5'd0, r8(2), 3'b100, r8(2), 7'b0111011));
    apply(mk1(2'b11, 3'd6, 3'b100), 1'b1);
    expect_out("R10 zext.w wide", 1'b0, rty(7'b0000100, 5'd0, r8(6), 3'b000, r8(6), 7'b0111011));
    apply(mk1(2'b11, 3'd6, 3'b100), 1'b0);
    expect_out("R10 zext.w narrow", 1'b1, 32'h0);
    apply(mk1(2'b11, 3'd6, 3'b110), 1'b1);
    expect_out("R11 code 110", 1'b1, 32'h0);
    apply(mk1(2'b11, 3'd6, 3'b111), 1'b1);
    expect_out("R11 code 111", 1'b1, 32'h0);
  endtask

  task automatic t_latency;
    apply(mk1(2'b10, 3'd1, 3'd2), 1'b1);
    @(negedge clk);
    insn_i = 16'h0013;
    #1;
    expect_out("R12 held before edge", 1'b0,
               rty(7'b0000001, r8(2), r8(1), 3'b000, r8(1), 7'b0110011));
    @(posedge clk); #1;
    expect_out("R12 updated after edge", 1'b1, 32'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    expect_out("R12 sync reset", 1'b0, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_outside();
    t_lbu();
    t_half_load();
    t_stores();
    t_word_ops();
    t_mul();
    t_unary();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule